// File: doc/BRIEF.md
# Bitmap Video Fetch and Pixel Serializer

This block sits behind a CRT controller in a bitmap display path. The controller supplies a linear memory-address counter and a scan-row counter once per character cell. From these the block forms a 13-bit offset that addresses two video RAMs, a bitmap plane and a colour plane. It reads one byte from each and turns the bitmap byte into eight consecutive pixels. Each pixel is either the cell's foreground colour or black. The colour is 3-bit RGB, one bit per gun.

A whole-screen flip mirrors the picture. The RAM offset is complemented, and the bits of each bitmap byte are sent out in the opposite order. The flip state is loaded through a one-bit write port and stores the inverse of the bit written. A display-enable input blanks whole cells. The block's clock is the pixel clock. A free-running phase counter, restarted by reset, marks a cell boundary every eight clocks.

Top module: `bitmap_pixel_pipe`

## Requirements
- R1: On each cell boundary clock edge (the first edge after reset is released, then every 8th edge), the block registers the RAM offset {MA[9:5], RA[2:0], MA[4:0]}, with the MA field in bits 12:8 and bits 4:0. The offset is on `ram_addr` after that edge and holds until the next boundary. MA[13:10] has no effect.
- R2: When the flip state is active at the boundary edge, the registered offset is the R1 value XOR 13'h1FFF.
- R3: Unflipped, the eight pixels of a cell come from the bitmap byte most significant bit first.
- R4: Flipped, the eight pixels come from the bitmap byte least significant bit first.
- R5: A pixel whose bitmap bit is 1 shows the foreground colour, which is bits 7:5 of the colour byte at the same offset. A pixel whose bitmap bit is 0 is black (all outputs 0).
- R6: Colour bit 2 drives `px_red`, bit 1 drives `px_grn` and bit 0 drives `px_blu`.
- R7: A write of value v on the flip port sets the flip state to !v. Reset leaves the state unflipped. A write changes only cells whose boundary edge comes after it.
- R8: Pixel j (0..7) of the cell captured at boundary edge n appears on the pixel outputs after edge n+8+j, so consecutive cells leave no gap.
- R9: A cell whose display enable is low at its boundary edge gives eight black pixels.
- R10: While reset is high, `ram_addr` is 0 and the pixel outputs are 0. The eight pixel slots after reset is released are black.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| crtc_ma | input | 14 | Memory-address counter from the CRT controller |
| crtc_ra | input | 3 | Scan-row counter from the CRT controller |
| disp_en | input | 1 | Display enable, sampled per cell |
| flip_we | input | 1 | Flip state write strobe |
| flip_wdata | input | 1 | Flip write value (stored inverted) |
| ram_addr | output | 13 | Offset to both video RAMs |
| bmp_rdata | input | 8 | Bitmap RAM read data |
| clr_rdata | input | 8 | Colour RAM read data |
| px_red | output | 1 | Red pixel bit |
| px_grn | output | 1 | Green pixel bit |
| px_blu | output | 1 | Blue pixel bit |

## Verification
The RAM offset is due one clock after the boundary edge that captured it. The driver checks it on the falling edge that follows that capture. Pixel j of a cell is due eight plus j clocks after the cell's boundary edge. The expected-pixel queue is therefore seeded with eight black slots for the post-reset interval, and the monitor pops one item on every falling edge. Flip writes are placed in the middle of a cell, and the model changes its flip state only after it has computed that cell's expectation. This keeps the write effective from the next boundary, matching the design.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
  // Per-cell control captured at the cell boundary and carried with the data
  typedef struct packed {
    logic de;
    logic flip;
  } cell_ctl_t;

  localparam int RGB_W = 3;
endpackage

// File: rtl/bpp_addr_gen.sv
module bpp_addr_gen import bpp_pkg::*; #(
  parameter int MA_W = 14,
  parameter int RA_W = 3,
  parameter int LO_W = 5,
  parameter int HI_W = 5,
  localparam int ADDR_W = HI_W + RA_W + LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [MA_W-1:0]   ma,
  input  logic [RA_W-1:0]   ra,
  input  logic              de,
  input  logic              flip,
  output logic [ADDR_W-1:0] addr_q,
  output cell_ctl_t         ctl_q
);
  localparam int MA_FIELD_W = LO_W + HI_W;

  logic [ADDR_W-1:0] linear;
  logic [ADDR_W-1:0] mirrored;
  logic              ma_unused;

  // Row counter is interleaved between the two memory-address fields
  assign linear    = {ma[MA_FIELD_W-1:LO_W], ra, ma[LO_W-1:0]};
  assign mirrored  = linear ^ {ADDR_W{flip}};
  assign ma_unused = ^ma;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      ctl_q  <= '0;
    end else if (cap) begin
      addr_q     <= mirrored;
      ctl_q.de   <= de;
      ctl_q.flip <= flip;
    end
  end
endmodule

// File: rtl/bpp_shifter.sv
module bpp_shifter import bpp_pkg::*; #(
  parameter int PIX_W   = 8,
  parameter int COL_LSB = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PIX_W-1:0] bmp,
  input  logic [PIX_W-1:0] clr,
  input  cell_ctl_t        ctl,
  output logic             cur_bit,
  output logic [RGB_W-1:0] cur_col,
  output logic             cur_de
);
  logic [PIX_W-1:0] bmp_rev;
  logic [PIX_W-1:0] sr;
  logic             clr_unused;

  // Mirror the byte at load so the shift direction never changes
  for (genvar i = 0; i < PIX_W; i++) begin : g_rev
    assign bmp_rev[i] = bmp[PIX_W-1-i];
  end

  assign clr_unused = ^clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      cur_col <= '0;
      cur_de  <= 1'b0;
    end else if (load) begin
      sr      <= ctl.flip ? bmp_rev : bmp;
      cur_col <= clr[COL_LSB +: RGB_W];
      cur_de  <= ctl.de;
    end else begin
      sr <= {sr[PIX_W-2:0], 1'b0};
    end
  end

  assign cur_bit = sr[PIX_W-1];
endmodule

// File: rtl/bpp_pix_out.sv
module bpp_pix_out import bpp_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_bit,
  input  logic [RGB_W-1:0] pix_col,
  input  logic             pix_de,
  output logic             red,
  output logic             grn,
  output logic             blu
);
  logic [RGB_W-1:0] shown;

  assign shown = (pix_bit && pix_de) ? pix_col : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      red <= 1'b0;
      grn <= 1'b0;
      blu <= 1'b0;
    end else begin
      red <= shown[2];
      grn <= shown[1];
      blu <= shown[0];
    end
  end
endmodule

// File: rtl/bitmap_pixel_pipe.sv
module bitmap_pixel_pipe import bpp_pkg::*; #(
  parameter int MA_W    = 14,
  parameter int RA_W    = 3,
  parameter int LO_W    = 5,
  parameter int HI_W    = 5,
  parameter int PIX_W   = 8,
  parameter int COL_LSB = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [MA_W-1:0]             crtc_ma,
  input  logic [RA_W-1:0]             crtc_ra,
  input  logic                        disp_en,
  input  logic                        flip_we,
  input  logic                        flip_wdata,
  output logic [HI_W+RA_W+LO_W-1:0]   ram_addr,
  input  logic [PIX_W-1:0]            bmp_rdata,
  input  logic [PIX_W-1:0]            clr_rdata,
  output logic                        px_red,
  output logic                        px_grn,
  output logic                        px_blu
);
  localparam int ADDR_W = HI_W + RA_W + LO_W;
  localparam int PH_W   = (PIX_W > 1) ? $clog2(PIX_W) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PIX_W - 1);

  logic [PH_W-1:0]  phase;
  logic             cap;
  logic             load;
  logic             flip_q;
  cell_ctl_t        fetch_ctl;
  logic             cell_bit;
  logic [RGB_W-1:0] cell_col;
  logic             cell_de;

  // Cell phase: capture on phase 0, hand over to the shifter on the last pixel
  always_ff @(posedge clk) begin
    if (rst)                 phase <= '0;
    else if (phase == PH_LAST) phase <= '0;
    else                     phase <= phase + 1'b1;
  end

  assign cap  = (phase == '0);
  assign load = (phase == PH_LAST);

  // Flip state holds the complement of what was written
  always_ff @(posedge clk) begin
    if (rst)          flip_q <= 1'b0;
    else if (flip_we) flip_q <= ~flip_wdata;
  end

  bpp_addr_gen #(
    .MA_W(MA_W), .RA_W(RA_W), .LO_W(LO_W), .HI_W(HI_W)
  ) u_addr (
    .clk   (clk),
    .rst   (rst),
    .cap   (cap),
    .ma    (crtc_ma),
    .ra    (crtc_ra),
    .de    (disp_en),
    .flip  (flip_q),
    .addr_q(ram_addr),
    .ctl_q (fetch_ctl)
  );

  bpp_shifter #(
    .PIX_W(PIX_W), .COL_LSB(COL_LSB)
  ) u_shift (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .bmp    (bmp_rdata),
    .clr    (clr_rdata),
    .ctl    (fetch_ctl),
    .cur_bit(cell_bit),
    .cur_col(cell_col),
    .cur_de (cell_de)
  );

  bpp_pix_out u_out (
    .clk    (clk),
    .rst    (rst),
    .pix_bit(cell_bit),
    .pix_col(cell_col),
    .pix_de (cell_de),
    .red    (px_red),
    .grn    (px_grn),
    .blu    (px_blu)
  );
endmodule

// File: rtl/bpp_checker.sv
module bpp_checker #(
  parameter int PH_W   = 3,
  parameter int PIX_W  = 8,
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic [PH_W-1:0]   phase,
  input logic              flip_we,
  input logic              flip_wdata,
  input logic              flip_q,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              cell_bit,
  input logic [2:0]        cell_col,
  input logic              cell_de,
  input logic              px_red,
  input logic              px_grn,
  input logic              px_blu
);
  // R1: offset only moves on a cell boundary
  a_r1_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (phase != '0) |=> $stable(ram_addr));

  // R8: cells repeat every PIX_W clocks
  a_r8_phase_wrap: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_W'(PIX_W - 1)) |=> (phase == '0));

  // R7: stored flip is the complement of the written bit
  a_r7_flip_inverse: assert property (@(posedge clk) disable iff (rst)
    flip_we |=> (flip_q == !$past(flip_wdata)));

  // R5: clear bitmap bit gives black
  a_r5_clear_black: assert property (@(posedge clk) disable iff (rst)
    !cell_bit |=> ({px_red, px_grn, px_blu} == 3'b000));

  // R6: set bit routes colour bits to the guns
  a_r6_color_route: assert property (@(posedge clk) disable iff (rst)
    (cell_bit && cell_de) |=> ({px_red, px_grn, px_blu} == $past(cell_col)));

  // R9: blanked cell gives black
  a_r9_blank: assert property (@(posedge clk) disable iff (rst)
    !cell_de |=> ({px_red, px_grn, px_blu} == 3'b000));
endmodule

bind bitmap_pixel_pipe bpp_checker #(
  .PH_W(PH_W), .PIX_W(PIX_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .phase     (phase),
  .flip_we   (flip_we),
  .flip_wdata(flip_wdata),
  .flip_q    (flip_q),
  .ram_addr  (ram_addr),
  .cell_bit  (cell_bit),
  .cell_col  (cell_col),
  .cell_de   (cell_de),
  .px_red    (px_red),
  .px_grn    (px_grn),
  .px_blu    (px_blu)
);

// File: tb/tb_bitmap_pixel_pipe.sv
`timescale 1ns/1ps
module tb_bitmap_pixel_pipe;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] crtc_ma = '0;
  logic [2:0]  crtc_ra = '0;
  logic        disp_en = 1'b0;
  logic        flip_we = 1'b0;
  logic        flip_wdata = 1'b0;
  logic [12:0] ram_addr;
  logic [7:0]  bmp_rdata;
  logic [7:0]  clr_rdata;
  logic        px_red, px_grn, px_blu;

  logic [7:0] bmp_mem [8192];
  logic [7:0] clr_mem [8192];

  logic [2:0] exp_q [$];
  string      tag_q [$];
  int n_cmp = 0;
  int n_bad = 0;
  logic flip_m = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  bitmap_pixel_pipe dut (
    .clk(clk), .rst(rst), .crtc_ma(crtc_ma), .crtc_ra(crtc_ra),
    .disp_en(disp_en), .flip_we(flip_we), .flip_wdata(flip_wdata),
    .ram_addr(ram_addr), .bmp_rdata(bmp_rdata), .clr_rdata(clr_rdata),
    .px_red(px_red), .px_grn(px_grn), .px_blu(px_blu)
  );

  // Synchronous RAM model, one clock read latency
  always @(posedge clk) begin
    bmp_rdata <= bmp_mem[ram_addr];
    clr_rdata <= clr_mem[ram_addr];
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_cell(input logic [13:0] ma, input logic [2:0] ra,
                          input logic de, input int flip_cmd);
    logic [12:0] off;
    logic [7:0]  b;
    logic [2:0]  c;
    logic        bv;
    off = {ma[9:5], ra, ma[4:0]};
    if (flip_m) off = off ^ 13'h1FFF;
    b = bmp_mem[off];
    c = clr_mem[off][7:5];
    for (int j = 0; j < 8; j++) begin
      bv = flip_m ? b[j] : b[7-j];
      exp_q.push_back((de && bv) ? c : 3'b000);
      if (!de)        tag_q.push_back("R9 blank cell");
      else if (flip_m) tag_q.push_back("R4 R7 R8 flipped pixel");
      else            tag_q.push_back("R3 R5 R6 R8 pixel");
    end
    crtc_ma = ma;
    crtc_ra = ra;
    disp_en = de;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 0) check(flip_m ? "R2 flipped offset" : "R1 offset",
                        int'(ram_addr), int'(off));
      if (i == 3 && flip_cmd >= 0) begin
        flip_we    = 1'b1;
        flip_wdata = flip_cmd[0];
      end
      if (i == 4) flip_we = 1'b0;
    end
    if (flip_cmd >= 0) flip_m = ~flip_cmd[0];
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    for (int a = 0; a < 8192; a++) begin
      bmp_mem[a] = 8'((a * 29) ^ (a >> 3));
      clr_mem[a] = 8'((a * 53) ^ (a >> 4));
    end
    bmp_mem[0]       = 8'h81;  clr_mem[0]       = 8'hA0;
    bmp_mem[13'h1FFF] = 8'h01; clr_mem[13'h1FFF] = 8'hE0;

    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R10 reset offset", int'(ram_addr), 0);
    check("R10 reset pixel", int'({px_red, px_grn, px_blu}), 0);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) begin
      exp_q.push_back(3'b000);
      tag_q.push_back("R10 post-reset slot");
    end
    fork
      forever begin
        @(negedge clk);
        if (exp_q.size() > 0) begin
          logic [2:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, int'({px_red, px_grn, px_blu}), int'(e));
        end
      end
    join_none

    run_cell(14'h0000, 3'd0, 1'b1, -1);
    run_cell(14'h03FF, 3'd7, 1'b1, -1);
    run_cell(14'h3C21, 3'd5, 1'b1, -1);  // R1: MA[13:10] ignored
    run_cell(14'h0155, 3'd2, 1'b1, -1);
    run_cell(14'h02AA, 3'd3, 1'b0, -1);  // R9
    run_cell(14'h0123, 3'd6, 1'b1, 0);   // R7: write 0 -> flipped
    run_cell(14'h0123, 3'd6, 1'b1, -1);
    run_cell(14'h03FF, 3'd7, 1'b1, -1);  // R2: mirrors to offset 0
    run_cell(14'h0000, 3'd0, 1'b1, -1);
    run_cell(14'h0000, 3'd0, 1'b0, -1);
    run_cell(14'h0311, 3'd1, 1'b1, 1);   // R7: write 1 -> unflipped
    run_cell(14'h0311, 3'd1, 1'b1, -1);
    run_cell(14'h0042, 3'd4, 1'b1, -1);

    wait (exp_q.size() == 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset offset again", int'(ram_addr), 0);
    check("R10 reset pixel again", int'({px_red, px_grn, px_blu}), 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R8 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule